// File: doc/BRIEF.md
# Washer Agitation Sequencer

This block runs the agitation phase of a laundry washer. It works from a fast system clock and derives its own 0.1 s tick. Three pushbuttons drive it: start/stop, mode and duration. While a wash runs it turns the drum forward for the mode's on time, rests for the mode's off time, turns in reverse for the on time, rests again, and repeats. The wash timer stops the cycle when the selected duration has elapsed.

The mode and duration selections step on each rising edge of their keys and wrap around. They can only be changed while no wash is in progress. A finished wash puts both selections back to Standard and 15 minutes, and the block then waits for the next start. The start/stop key toggles between running and paused. A pause keeps the elapsed wash time. The agitation pattern restarts with a forward interval when the wash resumes.

All timing is counted in ticks of 0.1 s. `TICK_DIV` sets how many clock cycles make one tick. `UNIT_TICKS` sets how many ticks make one 0.5 s agitation unit. `TICKS_PER_MIN` sets how many ticks make one minute of wash time.

Top module: `wash_seq`

## Requirements
- R1: After reset the block is idle. `mode_o` is 0 (Standard), `dur_o` is 0 (15 min), and `running`, `done`, `motor_fwd` and `motor_rev` are all 0.
- R2: While idle, each rising edge of `key_mode` steps `mode_o` in the order Standard (0), Strong (1), Gentle (2) and back to Standard. Holding the key high gives only one step.
- R3: While idle, each rising edge of `key_dur` steps `dur_o` in the order 15 min (0), 10 min (1), 5 min (2) and back to 15 min.
- R4: A rising edge of `key_start` starts a wash from idle. During a wash it toggles between running and paused. `running` is 1 only while the wash is running.
- R5: While running, the motor outputs follow the order forward on, both off, reverse on, both off, forward on. `motor_fwd` and `motor_rev` are never 1 in the same cycle.
- R6: Measured in ticks, the on and off intervals are 10 and 4 units for Strong, 7 and 3 units for Standard, and 5 and 3 units for Gentle. One unit is `UNIT_TICKS` ticks. Every interval after the first is exact to the tick.
- R7: A wash ends after `minutes × TICKS_PER_MIN` ticks of running time. In the cycle it ends, `done` pulses high for one cycle, and `running`, `motor_fwd` and `motor_rev` are 0.
- R8: When a wash ends, `mode_o` returns to 0 and `dur_o` returns to 0.
- R9: While paused, both motor outputs are 0 and the elapsed time is held. After resume, counting continues from the held value and the pattern begins with forward.
- R10: A mode or duration key press while a wash is running or paused leaves `mode_o` and `dur_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_start | input | 1 | Start/stop key; acts on its rising edge |
| key_mode | input | 1 | Mode step key; acts on its rising edge |
| key_dur | input | 1 | Duration step key; acts on its rising edge |
| motor_fwd | output | 1 | Forward motor drive |
| motor_rev | output | 1 | Reverse motor drive |
| mode_o | output | 2 | Selected mode: 0 Standard, 1 Strong, 2 Gentle |
| dur_o | output | 2 | Selected duration: 0 15 min, 1 10 min, 2 5 min |
| running | output | 1 | High while a wash is counting |
| done | output | 1 | One-cycle pulse when a wash finishes |

## Verification
The bench builds the block with `TICK_DIV` = 2, `UNIT_TICKS` = 5 and `TICKS_PER_MIN` = 60. One tick is then two cycles and a 5-minute wash is 600 cycles. This makes it practical to measure every interval length of all three modes to the cycle and to run complete washes to their end, including one with a pause in it and one at the 10-minute duration. The interval lengths in ticks are the same as at full scale. Only the tick period and the minute count are smaller, so the order of the pattern, its exact durations and the wrap-around of the selections are the same as the full-rate build.

// File: rtl/wash_pkg.sv
package wash_pkg;

    typedef enum logic [1:0] {
        MODE_STD    = 2'd0,
        MODE_STRONG = 2'd1,
        MODE_GENTLE = 2'd2
    } wmode_e;

    typedef enum logic [1:0] {
        DUR_LONG  = 2'd0,
        DUR_MID   = 2'd1,
        DUR_SHORT = 2'd2
    } wdur_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_RUN,
        T_PAUSE
    } tstate_e;

    typedef enum logic [1:0] {
        A_STOP,
        A_ON,
        A_OFF
    } astate_e;

    typedef struct packed {
        wmode_e mode;
        wdur_e  dur;
    } wsel_t;

    localparam wsel_t SEL_DEFAULT = '{mode: MODE_STD, dur: DUR_LONG};
    localparam int unsigned MAX_ON_UNITS = 10;
    localparam int unsigned MAX_MINUTES  = 15;

    function automatic wmode_e next_mode(input wmode_e m);
        case (m)
            MODE_STD:    return MODE_STRONG;
            MODE_STRONG: return MODE_GENTLE;
            default:     return MODE_STD;
        endcase
    endfunction

    function automatic wdur_e next_dur(input wdur_e d);
        case (d)
            DUR_LONG: return DUR_MID;
            DUR_MID:  return DUR_SHORT;
            default:  return DUR_LONG;
        endcase
    endfunction

    function automatic int unsigned on_units(input wmode_e m);
        case (m)
            MODE_STRONG: return 10;
            MODE_GENTLE: return 5;
            default:     return 7;
        endcase
    endfunction

    function automatic int unsigned off_units(input wmode_e m);
        case (m)
            MODE_STRONG: return 4;
            default:     return 3;
        endcase
    endfunction

    function automatic int unsigned dur_minutes(input wdur_e d);
        case (d)
            DUR_MID:   return 10;
            DUR_SHORT: return 5;
            default:   return 15;
        endcase
    endfunction

endpackage

// File: rtl/wash_tick_gen.sv
module wash_tick_gen #(
    parameter int unsigned DIV = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wash_panel.sv
module wash_panel
    import wash_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  key_start,
    input  logic  key_mode,
    input  logic  key_dur,
    input  logic  idle,
    input  logic  expire,
    output wsel_t sel,
    output logic  start_press
);
    logic [2:0] prev;
    logic       mode_press;
    logic       dur_press;

    assign start_press = key_start & ~prev[0];
    assign mode_press  = key_mode  & ~prev[1];
    assign dur_press   = key_dur   & ~prev[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            sel  <= SEL_DEFAULT;
        end else begin
            prev <= {key_dur, key_mode, key_start};
            if (expire) begin
                sel <= SEL_DEFAULT;
            end else if (idle) begin
                if (mode_press) sel.mode <= next_mode(sel.mode);
                if (dur_press)  sel.dur  <= next_dur(sel.dur);
            end
        end
    end
endmodule

// File: rtl/wash_timer.sv
module wash_timer
    import wash_pkg::*;
#(
    parameter int unsigned TICKS_PER_MIN = 600
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    start_press,
    input  wdur_e   dur,
    output tstate_e state,
    output logic    expire,
    output logic    done
);
    localparam int unsigned EW = $clog2(MAX_MINUTES * TICKS_PER_MIN + 1);

    logic [EW-1:0] elapsed;
    logic [EW-1:0] last_tick;

    assign last_tick = EW'(dur_minutes(dur) * TICKS_PER_MIN - 1);
    assign expire    = (state == T_RUN) && tick && (elapsed == last_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= T_IDLE;
            elapsed <= '0;
            done    <= 1'b0;
        end else begin
            done <= expire;
            case (state)
                T_IDLE: begin
                    elapsed <= '0;
                    if (start_press) state <= T_RUN;
                end
                T_RUN: begin
                    if (expire) begin
                        state   <= T_IDLE;
                        elapsed <= '0;
                    end else begin
                        if (tick)        elapsed <= elapsed + 1'b1;
                        if (start_press) state   <= T_PAUSE;
                    end
                end
                T_PAUSE: begin
                    if (start_press) state <= T_RUN;
                end
                default: state <= T_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wash_agitator.sv
module wash_agitator
    import wash_pkg::*;
#(
    parameter int unsigned UNIT_TICKS = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   run,
    input  wmode_e mode,
    output logic   fwd,
    output logic   rev
);
    localparam int unsigned CW = $clog2(MAX_ON_UNITS * UNIT_TICKS);

    astate_e       st;
    logic          dir_rev;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len;

    always_comb begin
        if (st == A_OFF) len = CW'(off_units(mode) * UNIT_TICKS);
        else             len = CW'(on_units(mode) * UNIT_TICKS);
    end

    assign fwd = run && (st == A_ON) && !dir_rev;
    assign rev = run && (st == A_ON) &&  dir_rev;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st      <= A_STOP;
            cnt     <= '0;
            dir_rev <= 1'b0;
        end else begin
            case (st)
                A_STOP: begin
                    st      <= A_ON;
                    cnt     <= '0;
                    dir_rev <= 1'b0;
                end
                A_ON: if (tick) begin
                    if (cnt == len - 1'b1) begin
                        st  <= A_OFF;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                A_OFF: if (tick) begin
                    if (cnt == len - 1'b1) begin
                        st      <= A_ON;
                        cnt     <= '0;
                        dir_rev <= ~dir_rev;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= A_STOP;
            endcase
        end
    end
endmodule

// File: rtl/wash_seq.sv
module wash_seq
    import wash_pkg::*;
#(
    parameter int unsigned TICK_DIV      = 5_000_000,
    parameter int unsigned UNIT_TICKS    = 5,
    parameter int unsigned TICKS_PER_MIN = 600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_start,
    input  logic       key_mode,
    input  logic       key_dur,
    output logic       motor_fwd,
    output logic       motor_rev,
    output logic [1:0] mode_o,
    output logic [1:0] dur_o,
    output logic       running,
    output logic       done
);
    logic    tick;
    logic    start_press;
    logic    expire;
    wsel_t   sel;
    tstate_e tstate;

    wash_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    wash_panel u_panel (
        .clk         (clk),
        .rst         (rst),
        .key_start   (key_start),
        .key_mode    (key_mode),
        .key_dur     (key_dur),
        .idle        (tstate == T_IDLE),
        .expire      (expire),
        .sel         (sel),
        .start_press (start_press)
    );

    wash_timer #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .start_press (start_press),
        .dur         (sel.dur),
        .state       (tstate),
        .expire      (expire),
        .done        (done)
    );

    wash_agitator #(.UNIT_TICKS(UNIT_TICKS)) u_agit (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .run  (tstate == T_RUN),
        .mode (sel.mode),
        .fwd  (motor_fwd),
        .rev  (motor_rev)
    );

    assign running = (tstate == T_RUN);
    assign mode_o  = sel.mode;
    assign dur_o   = sel.dur;
endmodule

// File: rtl/wash_seq_chk.sv
module wash_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       motor_fwd,
    input logic       motor_rev,
    input logic [1:0] mode_o,
    input logic [1:0] dur_o,
    input logic       running,
    input logic       done
);
    // R5
    fwd_rev_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(motor_fwd && motor_rev));

    // R9
    motor_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!motor_fwd && !motor_rev));

    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> ($stable(mode_o) && $stable(dur_o)));

    // R8
    done_reset_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (mode_o == 2'd0 && dur_o == 2'd0 && !running));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd3) && (dur_o != 2'd3));
endmodule

bind wash_seq wash_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .motor_fwd (motor_fwd),
    .motor_rev (motor_rev),
    .mode_o    (mode_o),
    .dur_o     (dur_o),
    .running   (running),
    .done      (done)
);

// File: tb/wash_seq_bench.sv
module wash_seq_bench;
    localparam int D    = 2;
    localparam int UNIT = 5;
    localparam int TPM  = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_start = 1'b0;
    logic       key_mode  = 1'b0;
    logic       key_dur   = 1'b0;
    logic       motor_fwd, motor_rev, running, done;
    logic [1:0] mode_o, dur_o;

    int vectors = 0;
    int errors  = 0;
    int run_cycles = 0;

    always #5 clk = ~clk;

    wash_seq #(.TICK_DIV(D), .UNIT_TICKS(UNIT), .TICKS_PER_MIN(TPM)) u_wash_seq (
        .clk(clk), .rst(rst), .key_start(key_start), .key_mode(key_mode),
        .key_dur(key_dur), .motor_fwd(motor_fwd), .motor_rev(motor_rev),
        .mode_o(mode_o), .dur_o(dur_o), .running(running), .done(done)
    );

    always @(negedge clk) if (running) run_cycles++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic press(input int which);
        @(negedge clk);
        case (which)
            0: key_start = 1'b1;
            1: key_mode  = 1'b1;
            default: key_dur = 1'b1;
        endcase
        repeat (3) @(negedge clk);
        key_start = 1'b0; key_mode = 1'b0; key_dur = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_done(input string req, output int ok);
        int n = 0;
        ok = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        if (done) ok = 1;
        check(ok == 1, req, ok, 1);
    endtask

    // R1
    task automatic t_reset();
        check(mode_o == 2'd0, "R1 mode", mode_o, 0);
        check(dur_o == 2'd0, "R1 dur", dur_o, 0);
        check(!running && !done, "R1 status", {running, done}, 0);
        check(!motor_fwd && !motor_rev, "R1 motors", {motor_fwd, motor_rev}, 0);
    endtask

    // R2 R3
    task automatic t_wrap();
        press(1); check(mode_o == 2'd1, "R2 step1", mode_o, 1);
        press(1); check(mode_o == 2'd2, "R2 step2", mode_o, 2);
        press(1); check(mode_o == 2'd0, "R2 wrap", mode_o, 0);
        press(2); check(dur_o == 2'd1, "R3 step1", dur_o, 1);
        press(2); check(dur_o == 2'd2, "R3 step2", dur_o, 2);
        press(2); check(dur_o == 2'd0, "R3 wrap", dur_o, 0);
    endtask

    // R5 R6 R7 R8
    task automatic t_pattern(input int mpress, input int on_u, input int off_u, input string nm);
        int on_c, off_c, n, ok;
        on_c  = on_u * UNIT * D;
        off_c = off_u * UNIT * D;
        for (int i = 0; i < mpress; i++) press(1);
        press(2); press(2);
        @(negedge clk); key_start = 1'b1;
        n = 0;
        while (!motor_fwd && n < 20) begin @(negedge clk); n++; end
        check(motor_fwd && !motor_rev, {"R5 first fwd ", nm}, motor_fwd, 1);
        n = 0;
        while (motor_fwd) begin @(negedge clk); n++; end
        check(n >= on_c - D + 1 && n <= on_c, {"R6 first on ", nm}, n, on_c);
        n = 0;
        while (!motor_fwd && !motor_rev) begin @(negedge clk); n++; end
        check(n == off_c, {"R6 off1 ", nm}, n, off_c);
        check(motor_rev && !motor_fwd, {"R5 reverse ", nm}, motor_rev, 1);
        n = 0;
        while (motor_rev) begin @(negedge clk); n++; end
        check(n == on_c, {"R6 rev on ", nm}, n, on_c);
        n = 0;
        while (!motor_fwd && !motor_rev) begin @(negedge clk); n++; end
        check(n == off_c, {"R6 off2 ", nm}, n, off_c);
        check(motor_fwd, {"R5 fwd again ", nm}, motor_fwd, 1);
        key_start = 1'b0;
        wait_done({"R7 end ", nm}, ok);
        check(mode_o == 0 && dur_o == 0, {"R8 sel reset ", nm}, {mode_o, dur_o}, 0);
        check(!running && !motor_fwd && !motor_rev, {"R7 stopped ", nm},
              {running, motor_fwd, motor_rev}, 0);
        @(negedge clk);
        check(!done, {"R7 one pulse ", nm}, done, 0);
    endtask

    // R7 R4
    task automatic t_duration();
        int ok, lim;
        lim = 10 * TPM * D;
        press(2);
        run_cycles = 0;
        press(0);
        check(running, "R4 start", running, 1);
        wait_done("R7 10min end", ok);
        check(run_cycles >= lim - D + 1 && run_cycles <= lim, "R7 10min length", run_cycles, lim);
        check(dur_o == 0, "R8 dur back", dur_o, 0);
    endtask

    // R9 R10 R4
    task automatic t_pause();
        int ok, n, lim, quiet;
        lim = 5 * TPM * D;
        press(2); press(2);
        run_cycles = 0;
        press(0);
        repeat (100) @(negedge clk);
        press(1); press(2);
        check(mode_o == 0 && dur_o == 2, "R10 ignored running", {mode_o, dur_o}, 2);
        press(0);
        check(!running, "R4 paused", running, 1'b0);
        quiet = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (motor_fwd || motor_rev || running) quiet = 0;
        end
        check(quiet == 1, "R9 quiet pause", quiet, 1);
        press(1); press(2);
        check(mode_o == 0 && dur_o == 2, "R10 ignored paused", {mode_o, dur_o}, 2);
        @(negedge clk); key_start = 1'b1;
        n = 0;
        while (!motor_fwd && !motor_rev && n < 20) begin @(negedge clk); n++; end
        check(motor_fwd && !motor_rev, "R9 resume fwd", motor_fwd, 1);
        key_start = 1'b0;
        wait_done("R9 end", ok);
        check(run_cycles >= lim - 2 * D && run_cycles <= lim + 2 * D, "R9 held time", run_cycles, lim);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_pattern(1, 10, 4, "strong");
        t_pattern(0, 7, 3, "standard");
        t_pattern(2, 5, 3, "gentle");
        t_duration();
        t_pause();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule